// File: doc/BRIEF.md
# Serial Response Word Receiver

This block sits on the receive side of a slow serial link that carries response words back from a chain of remote high-voltage units. It deserializes asynchronous characters from a single line, checks each one, and rebuilds three consecutive characters into an 18-bit raw word. The low 16 bits form the response word. The top two bits are status bits that request an interrupt at one of two priority levels.

A clean, complete word is offered to an external input buffer as a one-cycle push with data. The status bits are turned into one-cycle set pulses for the high-priority and low-priority interrupt flip-flops, which live outside this block. Any fault in transmission does three things: it discards the word being built, pulses a transmission-error output with a fault code, and requests the high-priority interrupt. A pushed word whose low nibble reports a remote fault sets a sticky alarm output, meant to drive an external alarm. Only reset clears the alarm.

Top module: `rsp_receiver`

## Requirements
- R1: While reset is held and in the first cycle after it, `push`, `lam_hi_set`, `lam_lo_set`, `xmit_err` and `alarm` are 0 and `err_code` is 0.
- R2: A character is a low start bit, six data bits least significant first, a flag bit, a parity bit and two high stop bits. Each bit lasts `CLK_PER_BIT` clocks and is sampled at its centre.
- R3: A word is three characters: the first has flag 1 and holds raw bits 17..12, the next two have flag 0 and hold bits 11..6 and 5..0. When the third character is clean and the buffer is not full, `push` pulses for one cycle and `push_data` carries raw bits 15..0.
- R4: In the push cycle, raw bit 17 gives a one-cycle `lam_hi_set` pulse and raw bit 16 gives a one-cycle `lam_lo_set` pulse. These outputs only ever pulse high.
- R5: With `ODD_PARITY`=0, the data, flag and parity bits must hold an even number of ones. A failing character gives `xmit_err` with `err_code`=1, drops the partial word and makes the next character be treated as a first character. Parity is judged before the stop bits.
- R6: Framing faults give `xmit_err` with `err_code`=2. A flag-0 character where a first character is due is discarded. A flag-1 character in the second or third position drops the partial word and starts a new word. A low stop bit drops the partial word.
- R7: If `fifo_full` is high when a clean third character completes, there is no push and no `lam_lo_set`, and `xmit_err` pulses with `err_code`=3.
- R8: Every `xmit_err` pulse comes with a `lam_hi_set` pulse in the same cycle and never with `push`.
- R9: A pushed word whose low four bits are 12 or 13 sets `alarm` on the next cycle. `alarm` then stays high until reset. Other codes leave it unchanged.
- R10: A low pulse on `rx` that ends before the middle of the start bit is ignored: it produces no character and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Serial line, idle high |
| fifo_full | input | 1 | Input buffer cannot accept a word |
| push | output | 1 | One-cycle push of a clean word |
| push_data | output | 16 | Response word for the buffer |
| lam_hi_set | output | 1 | Set pulse, high-priority interrupt |
| lam_lo_set | output | 1 | Set pulse, low-priority interrupt |
| xmit_err | output | 1 | One-cycle transmission-error pulse |
| err_code | output | 2 | Fault kind with xmit_err: 1 parity, 2 framing, 3 overwrite |
| alarm | output | 1 | Sticky remote-fault alarm |

## Verification
The hardest states to reach from the ports are the resynchronisation paths. These are a flag-1 character arriving in the middle of a word, and a fault on the last character, which must leave the assembler expecting a first character and must not cause a second error on whatever follows. The bench has a character task that can flip the parity bit, clear the flag or pull the first stop bit low on any chosen character. It uses that task to build broken sequences and then sends a clean word, checking that the clean word is pushed intact. Overwrite is reached by holding `fifo_full` high for a whole word. A start-bit glitch shorter than half a bit tests the false-start path.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;

    localparam int CHAR_BITS = 6;
    localparam int WORD_BITS = 16;
    localparam int RAW_BITS  = 3 * CHAR_BITS;

    localparam logic [3:0] CODE_REMOTE_PARITY    = 4'd12;
    localparam logic [3:0] CODE_REMOTE_OVERWRITE = 4'd13;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_PARITY    = 2'd1,
        ERR_FRAME     = 2'd2,
        ERR_OVERWRITE = 2'd3
    } rx_err_e;

    typedef enum logic [1:0] {
        SLOT_HI  = 2'd0,
        SLOT_MID = 2'd1,
        SLOT_LO  = 2'd2
    } slot_e;

    typedef struct packed {
        logic [CHAR_BITS-1:0] data;
        logic                 flag;
        logic                 par_ok;
        logic                 stop_ok;
    } rx_char_t;

    function automatic logic parity_good(input logic [CHAR_BITS-1:0] d,
                                         input logic flag,
                                         input logic par,
                                         input logic odd);
        return (^{d, flag, par}) == odd;
    endfunction

    function automatic logic is_remote_fault(input logic [3:0] nib);
        return (nib == CODE_REMOTE_PARITY) || (nib == CODE_REMOTE_OVERWRITE);
    endfunction

endpackage

// File: rtl/rsp_char_rx.sv
module rsp_char_rx
    import rsp_rx_pkg::*;
#(
    parameter int CLK_PER_BIT = 20833,
    parameter bit ODD_PARITY  = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx,
    output logic     ch_valid,
    output rx_char_t ch
);
    localparam int TW    = $clog2(CLK_PER_BIT);
    localparam int HALF  = CLK_PER_BIT / 2;
    localparam int NSAMP = CHAR_BITS + 4;
    localparam int IW    = $clog2(NSAMP + 1);

    logic          rx_m, rx_s;
    logic          busy;
    logic [TW-1:0] timer;
    logic [IW-1:0] idx;
    logic [NSAMP-1:0] shreg;
    logic [NSAMP-1:0] sh_nxt;

    assign sh_nxt = {rx_s, shreg[NSAMP-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m     <= 1'b1;
            rx_s     <= 1'b1;
            busy     <= 1'b0;
            timer    <= '0;
            idx      <= '0;
            shreg    <= '0;
            ch_valid <= 1'b0;
            ch       <= '0;
        end else begin
            rx_m     <= rx;
            rx_s     <= rx_m;
            ch_valid <= 1'b0;
            if (!busy) begin
                if (!rx_s) begin
                    busy  <= 1'b1;
                    timer <= TW'(HALF - 1);
                    idx   <= '0;
                end
            end else if (timer != '0) begin
                timer <= timer - 1'b1;
            end else begin
                timer <= TW'(CLK_PER_BIT - 1);
                if (idx == '0) begin
                    if (rx_s) busy <= 1'b0;
                    else      idx  <= IW'(1);
                end else begin
                    shreg <= sh_nxt;
                    if (idx == IW'(NSAMP)) begin
                        busy       <= 1'b0;
                        ch_valid   <= 1'b1;
                        ch.data    <= sh_nxt[CHAR_BITS-1:0];
                        ch.flag    <= sh_nxt[CHAR_BITS];
                        ch.par_ok  <= parity_good(sh_nxt[CHAR_BITS-1:0],
                                                  sh_nxt[CHAR_BITS],
                                                  sh_nxt[CHAR_BITS+1],
                                                  ODD_PARITY);
                        ch.stop_ok <= sh_nxt[CHAR_BITS+2] & sh_nxt[CHAR_BITS+3];
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    char_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ch_valid |=> !ch_valid);

endmodule

// File: rtl/rsp_word_asm.sv
module rsp_word_asm
    import rsp_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ch_valid,
    input  rx_char_t             ch,
    input  logic                 fifo_full,
    output logic                 push,
    output logic [WORD_BITS-1:0] push_data,
    output logic                 lam_hi_set,
    output logic                 lam_lo_set,
    output logic                 xmit_err,
    output rx_err_e              err_code,
    output logic                 remote_fault
);
    slot_e                       slot;
    logic [2*CHAR_BITS-1:0]      acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot         <= SLOT_HI;
            acc          <= '0;
            push         <= 1'b0;
            push_data    <= '0;
            lam_hi_set   <= 1'b0;
            lam_lo_set   <= 1'b0;
            xmit_err     <= 1'b0;
            err_code     <= ERR_NONE;
            remote_fault <= 1'b0;
        end else begin
            push         <= 1'b0;
            lam_hi_set   <= 1'b0;
            lam_lo_set   <= 1'b0;
            xmit_err     <= 1'b0;
            err_code     <= ERR_NONE;
            remote_fault <= 1'b0;
            if (ch_valid) begin
                if (!ch.par_ok) begin
                    xmit_err   <= 1'b1;
                    lam_hi_set <= 1'b1;
                    err_code   <= ERR_PARITY;
                    slot       <= SLOT_HI;
                end else if (!ch.stop_ok) begin
                    xmit_err   <= 1'b1;
                    lam_hi_set <= 1'b1;
                    err_code   <= ERR_FRAME;
                    slot       <= SLOT_HI;
                end else if (slot == SLOT_HI) begin
                    if (ch.flag) begin
                        acc[2*CHAR_BITS-1:CHAR_BITS] <= ch.data;
                        slot <= SLOT_MID;
                    end else begin
                        xmit_err   <= 1'b1;
                        lam_hi_set <= 1'b1;
                        err_code   <= ERR_FRAME;
                    end
                end else if (ch.flag) begin
                    xmit_err   <= 1'b1;
                    lam_hi_set <= 1'b1;
                    err_code   <= ERR_FRAME;
                    acc[2*CHAR_BITS-1:CHAR_BITS] <= ch.data;
                    slot       <= SLOT_MID;
                end else if (slot == SLOT_MID) begin
                    acc[CHAR_BITS-1:0] <= ch.data;
                    slot <= SLOT_LO;
                end else begin
                    slot <= SLOT_HI;
                    if (fifo_full) begin
                        xmit_err   <= 1'b1;
                        lam_hi_set <= 1'b1;
                        err_code   <= ERR_OVERWRITE;
                    end else begin
                        push         <= 1'b1;
                        push_data    <= {acc[WORD_BITS-CHAR_BITS-1:0], ch.data};
                        lam_hi_set   <= acc[2*CHAR_BITS-1];
                        lam_lo_set   <= acc[2*CHAR_BITS-2];
                        remote_fault <= is_remote_fault(ch.data[3:0]);
                    end
                end
            end
        end
    end

    // R3
    push_after_char_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(ch_valid));

    // R7
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !$past(fifo_full));

    // R8
    err_raises_hi_chk: assert property (@(posedge clk) disable iff (rst)
        xmit_err |-> (lam_hi_set && !push && !lam_lo_set));

    // R4
    lo_only_with_push_chk: assert property (@(posedge clk) disable iff (rst)
        lam_lo_set |-> push);

endmodule

// File: rtl/rsp_receiver.sv
module rsp_receiver
    import rsp_rx_pkg::*;
#(
    parameter int CLK_PER_BIT = 20833,
    parameter bit ODD_PARITY  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx,
    input  logic                 fifo_full,
    output logic                 push,
    output logic [WORD_BITS-1:0] push_data,
    output logic                 lam_hi_set,
    output logic                 lam_lo_set,
    output logic                 xmit_err,
    output logic [1:0]           err_code,
    output logic                 alarm
);
    logic     ch_valid;
    rx_char_t ch;
    rx_err_e  err_kind;
    logic     remote_fault;

    rsp_char_rx #(
        .CLK_PER_BIT (CLK_PER_BIT),
        .ODD_PARITY  (ODD_PARITY)
    ) u_char (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx),
        .ch_valid (ch_valid),
        .ch       (ch)
    );

    rsp_word_asm u_asm (
        .clk          (clk),
        .rst          (rst),
        .ch_valid     (ch_valid),
        .ch           (ch),
        .fifo_full    (fifo_full),
        .push         (push),
        .push_data    (push_data),
        .lam_hi_set   (lam_hi_set),
        .lam_lo_set   (lam_lo_set),
        .xmit_err     (xmit_err),
        .err_code     (err_kind),
        .remote_fault (remote_fault)
    );

    assign err_code = err_kind;

    always_ff @(posedge clk) begin
        if (rst)                        alarm <= 1'b0;
        else if (push && remote_fault)  alarm <= 1'b1;
    end

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(alarm) |-> alarm);

    // R9
    alarm_from_push_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> $past(push));

endmodule

// File: tb/sim_rsp_receiver.sv
`timescale 1ns/1ps
module sim_rsp_receiver;
    localparam int CPB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx = 1'b1;
    logic        fifo_full = 1'b0;
    logic        push, lam_hi_set, lam_lo_set, xmit_err, alarm;
    logic [15:0] push_data;
    logic [1:0]  err_code;

    int n_chk = 0, n_err = 0;
    int n_push = 0, n_hi = 0, n_lo = 0, n_xe = 0;
    logic [15:0] last_data = '0;
    logic [1:0]  last_code = '0;

    always #10 clk = ~clk;

    rsp_receiver #(.CLK_PER_BIT(CPB), .ODD_PARITY(1'b0)) u0 (
        .clk(clk), .rst(rst), .rx(rx), .fifo_full(fifo_full),
        .push(push), .push_data(push_data), .lam_hi_set(lam_hi_set),
        .lam_lo_set(lam_lo_set), .xmit_err(xmit_err), .err_code(err_code),
        .alarm(alarm));

    always @(negedge clk) begin
        if (!rst) begin
            if (push)       begin n_push++; last_data = push_data; end
            if (lam_hi_set) n_hi++;
            if (lam_lo_set) n_lo++;
            if (xmit_err)   begin n_xe++; last_code = err_code; end
        end
    end

    // {status[1:0], word[15:0], expected push_data[15:0]}
    localparam logic [33:0] VEC [8] = '{
        {2'b00, 16'h1234, 16'h1234},
        {2'b01, 16'hABC5, 16'hABC5},
        {2'b10, 16'h0F0F, 16'h0F0F},
        {2'b11, 16'hFFF0, 16'hFFF0},
        {2'b00, 16'h0000, 16'h0000},
        {2'b01, 16'h8001, 16'h8001},
        {2'b10, 16'h5A5A, 16'h5A5A},
        {2'b00, 16'hC3B7, 16'hC3B7}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx = b;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send_char(input logic [5:0] d, input logic flag,
                             input logic pflip, input logic stop_bad);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(d[i]);
        send_bit(flag);
        send_bit((^{d, flag}) ^ pflip);
        send_bit(~stop_bad);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic send_word(input logic [17:0] w);
        send_char(w[17:12], 1'b1, 1'b0, 1'b0);
        send_char(w[11:6],  1'b0, 1'b0, 1'b0);
        send_char(w[5:0],   1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int p, h, l, e;
        do_reset();
        // R1 reset state
        chk({push, lam_hi_set, lam_lo_set, xmit_err, alarm, err_code} == 7'd0,
            "R1 reset outputs", {push, lam_hi_set, lam_lo_set, xmit_err, alarm, err_code}, 0);

        // R2 R3 R4 table of clean words
        for (int i = 0; i < 8; i++) begin
            p = n_push; h = n_hi; l = n_lo; e = n_xe;
            send_word(VEC[i][33:16]);
            chk(n_push == p + 1 && last_data == VEC[i][15:0], "R3 push data",
                last_data, VEC[i][15:0]);
            chk(n_hi - h == int'(VEC[i][33]) && n_lo - l == int'(VEC[i][32]),
                "R4 status pulses", {n_hi - h, n_lo - l}, {32'(VEC[i][33]), 32'(VEC[i][32])});
            chk(n_xe == e && alarm == 1'b0, "R2 clean framing", n_xe - e, 0);
        end

        // R5 parity fault on third character, then recovery
        p = n_push; h = n_hi; e = n_xe;
        send_char(6'h01, 1'b1, 1'b0, 1'b0);
        send_char(6'h02, 1'b0, 1'b0, 1'b0);
        send_char(6'h03, 1'b0, 1'b1, 1'b0);
        chk(n_xe == e + 1 && last_code == 2'd1, "R5 parity code", last_code, 1);
        chk(n_push == p && n_hi == h + 1, "R8 parity no push, hi set", n_push - p, 0);
        send_word({2'b00, 16'h2468});
        chk(n_push == p + 1 && last_data == 16'h2468 && n_xe == e + 1,
            "R5 recovery after parity", last_data, 16'h2468);

        // R6 flag 0 where a first character is due
        p = n_push; e = n_xe;
        send_char(6'h15, 1'b0, 1'b0, 1'b0);
        chk(n_xe == e + 1 && last_code == 2'd2 && n_push == p, "R6 stray flag0",
            last_code, 2);

        // R6 flag 1 in mid-word restarts the word
        p = n_push; e = n_xe;
        send_char(6'h3F, 1'b1, 1'b0, 1'b0);
        send_word({2'b00, 16'h1357});
        chk(n_xe == e + 1 && last_code == 2'd2, "R6 mid-word flag1 error", n_xe - e, 1);
        chk(n_push == p + 1 && last_data == 16'h1357, "R6 restart word pushed",
            last_data, 16'h1357);

        // R6 low stop bit on third character
        p = n_push; e = n_xe;
        send_char(6'h04, 1'b1, 1'b0, 1'b0);
        send_char(6'h05, 1'b0, 1'b0, 1'b0);
        send_char(6'h06, 1'b0, 1'b0, 1'b1);
        chk(n_xe == e + 1 && last_code == 2'd2 && n_push == p, "R6 stop bit low",
            last_code, 2);

        // R7 overwrite when buffer is full
        p = n_push; h = n_hi; l = n_lo; e = n_xe;
        fifo_full = 1'b1;
        send_word({2'b01, 16'h0777});
        fifo_full = 1'b0;
        chk(n_xe == e + 1 && last_code == 2'd3, "R7 overwrite code", last_code, 3);
        chk(n_push == p && n_lo == l && n_hi == h + 1, "R7 no push, no lo",
            {n_push - p, n_lo - l}, 0);

        // R10 short glitch
        p = n_push; e = n_xe;
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (4 * CPB) @(negedge clk);
        chk(n_xe == e && n_push == p, "R10 glitch ignored", n_xe - e, 0);
        send_word({2'b00, 16'h4321});
        chk(n_push == p + 1 && last_data == 16'h4321 && n_xe == e,
            "R10 word after glitch", last_data, 16'h4321);

        // R9 alarm on remote code 12, sticky
        send_word({2'b00, 16'h012C});
        chk(alarm == 1'b1, "R9 alarm on code 12", alarm, 1);
        send_word({2'b00, 16'h0125});
        chk(alarm == 1'b1, "R9 alarm sticky", alarm, 1);
        do_reset();
        chk(alarm == 1'b0, "R1 alarm cleared by reset", alarm, 0);
        send_word({2'b00, 16'h00AE});
        chk(alarm == 1'b0, "R9 code 14 no alarm", alarm, 0);
        send_word({2'b00, 16'h003D});
        chk(alarm == 1'b1, "R9 alarm on code 13", alarm, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule